// File: doc/BRIEF.md
# Signed-Digit Modulo Adder

This block adds two radix-2 signed-digit operands of `N` digits each without any carry chain. Every digit is held on two bits and takes a value from {−1, 0, +1}. Each digit position splits the pair of input digits into a transfer digit, which goes to the next higher position, and an interim digit, which stays. The choice between the two possible splits of a pair whose sum is ±1 depends only on whether a digit one position lower is negative. The final digit is the incoming transfer plus the interim digit, and it always stays in range. The delay of the adder is therefore the same for every `N`.

A two-bit mode input selects what happens to the transfer out of the top position. In plain mode it becomes an extra result digit. In the modulo 2^N mode it is dropped. In the modulo 2^N−1 mode it is fed back into position 0. In the modulo 2^N+1 mode it is negated and then fed back into position 0. The modulo results always fit in `N` digits, and they may be a negative representative of the residue class. The block is purely combinational and is meant for residue datapaths, where the carry-free end-around path keeps every channel at the same depth.

Top module: `sd_mod_adder`

## Requirements
- R1: A digit is coded on two bits: 2'b00 is 0, 2'b01 is +1 and 2'b10 is −1. Inputs never carry 2'b11, and no output digit is ever 2'b11.
- R2: At every position, 2·transfer + interim equals the sum of the two input digits. Output digit i equals the transfer into position i plus interim digit i, and it lies in {−1, 0, +1}.
- R3: An input pair (+1,+1) yields transfer +1 and interim 0. A pair (−1,−1) yields transfer −1 and interim 0. A pair whose digit sum is 0 yields transfer 0 and interim 0.
- R4: A pair of 0 and +1 yields transfer +1 and interim −1 when neither digit one position lower is −1. Otherwise it yields transfer 0 and interim +1.
- R5: A pair of 0 and −1 yields transfer 0 and interim −1 when neither digit one position lower is −1. Otherwise it yields transfer −1 and interim +1.
- R6: With mode_i = 0 (plain), position 0 sees a transfer of 0 and a clear lower-negative flag, and sum_o digit N carries the top transfer. The value of the N+1 digits equals x + y exactly. With both inputs zero, the output is all zero.
- R7: With mode_i = 1, the top transfer is discarded. The output value is congruent to x + y modulo 2^N, and digit N is 0.
- R8: With mode_i = 2, the top transfer feeds position 0, and position 0's lower-negative flag is set when either top input digit is −1. The result is congruent to x + y modulo 2^N−1, and digit N is 0.
- R9: With mode_i = 3, the negated top transfer feeds position 0, and position 0's flag is set when either top input digit is +1. The result is congruent to x + y modulo 2^N+1, digit N is 0, and a negative representative is allowed.
- R10: With N = 3 and mode_i = 3, x = (+1,+1,0) plus y = (0,+1,0), written most significant digit first, gives (0,0,−1), that is −1 ≡ 8 (mod 9).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | 0 plain, 1 mod 2^N, 2 mod 2^N−1, 3 mod 2^N+1 |
| opa_i | input | 2*N | Operand x, digit i on bits [2i+1:2i] |
| opb_i | input | 2*N | Operand y, same layout |
| sum_o | output | 2*N+2 | Result digits 0..N, digit N used only in plain mode |

## Verification
On a 3-digit instance, every pair of operands is applied in every mode. This covers each digit-pair rule, with both settings of the lower-negative flag and both signs of the end-around transfer, and so separates a wrong split table from a wrong feedback path. On an 8-digit instance, all-positive, all-negative, alternating and cancelling operands reach the extremes of the range and the longest runs of equal transfers, and random operands cover the remaining mixes. Each result is compared digit by digit with an independent model of the rules, and its value is also checked for congruence and width against the true sum. The value check shows whether a wrong result is a legal alternative representation or an arithmetic error.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;
  typedef logic [1:0] sdig_t;

  localparam sdig_t DIG_ZERO = 2'b00;
  localparam sdig_t DIG_POS  = 2'b01;
  localparam sdig_t DIG_NEG  = 2'b10;
  localparam sdig_t DIG_BAD  = 2'b11;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_POW2   = 2'd1,
    MODE_POW2M1 = 2'd2,
    MODE_POW2P1 = 2'd3
  } add_mode_e;

  function automatic int dig_val(sdig_t d);
    case (d)
      DIG_POS: return 1;
      DIG_NEG: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic logic dig_ok(sdig_t d);
    return d != DIG_BAD;
  endfunction

  // values outside one digit map to the unused code so checks can see them
  function automatic sdig_t dig_enc(int v);
    case (v)
      1:       return DIG_POS;
      -1:      return DIG_NEG;
      0:       return DIG_ZERO;
      default: return DIG_BAD;
    endcase
  endfunction

  // returns {transfer, interim}
  function automatic logic [3:0] split_pair(sdig_t a, sdig_t b, logic lower_neg);
    int t;
    t = dig_val(a) + dig_val(b);
    case (t)
      2:  return {DIG_POS, DIG_ZERO};
      -2: return {DIG_NEG, DIG_ZERO};
      1:  return lower_neg ? {DIG_ZERO, DIG_POS} : {DIG_POS, DIG_NEG};
      -1: return lower_neg ? {DIG_NEG, DIG_POS} : {DIG_ZERO, DIG_NEG};
      default: return {DIG_ZERO, DIG_ZERO};
    endcase
  endfunction
endpackage

// File: rtl/sdadd_cell.sv
module sdadd_cell
  import sdadd_pkg::*;
(
  input  logic [1:0] x_dig,
  input  logic [1:0] y_dig,
  input  logic       lower_neg,
  output logic [1:0] xfer_o,
  output logic [1:0] intr_o
);
  int pair_sum;

  always_comb begin
    {xfer_o, intr_o} = split_pair(x_dig, y_dig, lower_neg);
    pair_sum = dig_val(x_dig) + dig_val(y_dig);
    if (dig_ok(x_dig) && dig_ok(y_dig)) begin
      // R2
      pair_identity_chk: assert (2 * dig_val(xfer_o) + dig_val(intr_o) == pair_sum);
      // R3
      double_pos_chk: assert (!(x_dig == DIG_POS && y_dig == DIG_POS) ||
                              (xfer_o == DIG_POS && intr_o == DIG_ZERO));
      // R4
      pos_clear_chk: assert (!(pair_sum == 1 && !lower_neg) ||
                             (xfer_o == DIG_POS && intr_o == DIG_NEG));
      // R5
      neg_borrow_chk: assert (!(pair_sum == -1 && lower_neg) ||
                              (xfer_o == DIG_NEG && intr_o == DIG_POS));
    end
  end
endmodule

// File: rtl/sdadd_wrap.sv
module sdadd_wrap
  import sdadd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] top_x,
  input  logic [1:0] top_y,
  input  logic [1:0] top_xfer,
  output logic [1:0] low_xfer,
  output logic       low_flag
);
  add_mode_e md;

  always_comb begin
    md = add_mode_e'(mode);
    case (md)
      MODE_POW2M1: begin
        low_xfer = top_xfer;
        low_flag = (top_x == DIG_NEG) || (top_y == DIG_NEG);
      end
      MODE_POW2P1: begin
        low_xfer = {top_xfer[0], top_xfer[1]};
        low_flag = (top_x == DIG_POS) || (top_y == DIG_POS);
      end
      default: begin
        low_xfer = DIG_ZERO;
        low_flag = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sd_mod_adder.sv
module sd_mod_adder
  import sdadd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [1:0]     mode_i,
  input  logic [2*N-1:0] opa_i,
  input  logic [2*N-1:0] opb_i,
  output logic [2*N+1:0] sum_o
);
  localparam int TOP = N - 1;

  logic [N-1:0] low_neg;
  sdig_t        xfer [1:N];
  sdig_t        intr [0:N-1];
  sdig_t        wrap_xfer;
  logic         wrap_flag;
  logic         in_ok;

  sdadd_wrap u_wrap (
    .mode     (mode_i),
    .top_x    (opa_i[2*TOP +: 2]),
    .top_y    (opb_i[2*TOP +: 2]),
    .top_xfer (xfer[N]),
    .low_xfer (wrap_xfer),
    .low_flag (wrap_flag)
  );

  always_comb begin
    in_ok = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (!dig_ok(opa_i[2*k +: 2]) || !dig_ok(opb_i[2*k +: 2])) in_ok = 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dig
    sdig_t cin;

    if (g == 0) begin : g_low
      assign low_neg[g] = wrap_flag;
      assign cin        = wrap_xfer;
    end else begin : g_mid
      assign low_neg[g] = (opa_i[2*(g-1) +: 2] == DIG_NEG) ||
                          (opb_i[2*(g-1) +: 2] == DIG_NEG);
      assign cin        = xfer[g];
    end

    sdadd_cell u_cell (
      .x_dig     (opa_i[2*g +: 2]),
      .y_dig     (opb_i[2*g +: 2]),
      .lower_neg (low_neg[g]),
      .xfer_o    (xfer[g+1]),
      .intr_o    (intr[g])
    );

    assign sum_o[2*g +: 2] = dig_enc(dig_val(cin) + dig_val(intr[g]));

    always_comb begin
      if (in_ok) begin
        // R1
        digit_code_chk: assert (sum_o[2*g +: 2] != DIG_BAD);
      end
    end
  end

  assign sum_o[2*N +: 2] = (mode_i == MODE_PLAIN) ? xfer[N] : DIG_ZERO;
endmodule

// File: tb/sd_mod_adder_tb_top.sv
module sd_mod_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NS = 3;
  localparam int WD_LIMIT = 100000;

  typedef struct {
    bit          big;
    logic [1:0]  md;
    logic [15:0] x;
    logic [15:0] y;
  } item_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]      mode_w = '0, mode_s = '0;
  logic [2*NW-1:0] xw = '0, yw = '0;
  logic [2*NS-1:0] xs = '0, ys = '0;
  logic [2*NW+1:0] sw;
  logic [2*NS+1:0] ss;

  item_t q[$];
  int n_checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  sd_mod_adder #(.N(NW)) dut_i (.mode_i(mode_w), .opa_i(xw), .opb_i(yw), .sum_o(sw));
  sd_mod_adder #(.N(NS)) ex_i  (.mode_i(mode_s), .opa_i(xs), .opb_i(ys), .sum_o(ss));

  function automatic int dv(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? -1 : 0;
  endfunction

  function automatic longint sval(logic [17:0] v, int nd);
    longint acc = 0;
    for (int i = 0; i < nd; i++) acc += longint'(dv(v[2*i +: 2])) * (longint'(1) << i);
    return acc;
  endfunction

  function automatic logic [1:0] ec(int v);
    return (v == 1) ? 2'b01 : (v == -1) ? 2'b10 : (v == 0) ? 2'b00 : 2'b11;
  endfunction

  // independent restatement of the digit rules and the feedback per mode
  function automatic logic [17:0] model(logic [1:0] md, logic [15:0] xa, logic [15:0] ya, int n);
    int c[0:8];
    int u[0:7];
    logic [17:0] r = '0;
    int c0;
    for (int i = 0; i < n; i++) begin
      int a = dv(xa[2*i +: 2]);
      int b = dv(ya[2*i +: 2]);
      bit ln;
      if (i == 0) begin
        int ta = dv(xa[2*(n-1) +: 2]);
        int tb = dv(ya[2*(n-1) +: 2]);
        ln = (md == 2) ? (ta < 0 || tb < 0) : (md == 3) ? (ta > 0 || tb > 0) : 1'b0;
      end else begin
        ln = dv(xa[2*(i-1) +: 2]) < 0 || dv(ya[2*(i-1) +: 2]) < 0;
      end
      if (a + b == 2)       begin c[i+1] = 1;  u[i] = 0; end
      else if (a + b == -2) begin c[i+1] = -1; u[i] = 0; end
      else if (a + b == 0)  begin c[i+1] = 0;  u[i] = 0; end
      else if (a + b == 1)  begin c[i+1] = ln ? 0 : 1;   u[i] = ln ? 1 : -1; end
      else                  begin c[i+1] = ln ? -1 : 0;  u[i] = ln ? 1 : -1; end
    end
    c0 = (md == 2) ? c[n] : (md == 3) ? -c[n] : 0;
    for (int i = 0; i < n; i++) r[2*i +: 2] = ec(((i == 0) ? c0 : c[i]) + u[i]);
    r[2*n +: 2] = (md == 0) ? ec(c[n]) : 2'b00;
    return r;
  endfunction

  function automatic string mtag(logic [1:0] md);
    case (md)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_item(item_t it);
    int n = it.big ? NW : NS;
    logic [17:0] got = it.big ? 18'(sw) : 18'(ss);
    logic [17:0] exp = model(it.md, it.x, it.y, n);
    longint gv = sval(got, n + 1);
    longint tv = sval(18'(it.x), n) + sval(18'(it.y), n);
    longint m;
    bit no_bad = 1;
    for (int i = 0; i <= n; i++) if (got[2*i +: 2] == 2'b11) no_bad = 0;
    chk(no_bad, "R1 digit code", longint'(got), longint'(exp));
    chk(got == exp, {"R2 R3 R4 R5 digits ", mtag(it.md)}, longint'(got), longint'(exp));
    if (it.md == 0) begin
      chk(gv == tv, "R6 exact value", gv, tv);
    end else begin
      m = (it.md == 1) ? (longint'(1) << n) : (it.md == 2) ? (longint'(1) << n) - 1 : (longint'(1) << n) + 1;
      chk(((gv - tv) % m == 0) && got[2*n +: 2] == 2'b00 &&
          gv < (longint'(1) << n) && gv > -(longint'(1) << n),
          {mtag(it.md), " congruence/width"}, gv, tv);
    end
  endtask

  task automatic drive(bit big, logic [1:0] md, logic [15:0] x, logic [15:0] y);
    item_t it;
    @(negedge clk);
    if (big) begin mode_w = md; xw = x; yw = y; end
    else begin mode_s = md; xs = x[5:0]; ys = y[5:0]; end
    it.big = big; it.md = md; it.x = x; it.y = y;
    q.push_back(it);
  endtask

  function automatic logic [15:0] tri_code(int v, int n);
    logic [15:0] r = '0;
    int t = v;
    for (int i = 0; i < n; i++) begin
      r[2*i +: 2] = (t % 3 == 1) ? 2'b01 : (t % 3 == 2) ? 2'b10 : 2'b00;
      t = t / 3;
    end
    return r;
  endfunction

  function automatic logic [15:0] rnd_op();
    logic [15:0] r;
    for (int i = 0; i < NW; i++) begin
      int k = int'($urandom_range(0, 2));
      r[2*i +: 2] = (k == 1) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (q.size() > 0) check_item(q.pop_front());
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R6 idle state with zero operands
    chk(sw == '0, "R6 zero inputs", longint'(sw), 0);

    // R10 worked example, mod 9 on three digits
    drive(0, 2'd3, 16'b010100, 16'b000100);
    @(posedge clk); #1;
    chk(ss == 8'b00000010, "R10 example", longint'(ss), 2);

    // directed extremes on the wide instance, every mode
    for (int md = 0; md < 4; md++) begin
      drive(1, 2'(md), 16'h5555, 16'h5555);
      drive(1, 2'(md), 16'hAAAA, 16'hAAAA);
      drive(1, 2'(md), 16'h6666, 16'h6666);
      drive(1, 2'(md), 16'h5555, 16'hAAAA);
      drive(1, 2'(md), 16'h0001, 16'h5554);
      drive(1, 2'(md), 16'h4000, 16'h4000);
    end

    // every operand pair on the narrow instance, every mode
    for (int md = 0; md < 4; md++)
      for (int a = 0; a < 27; a++)
        for (int b = 0; b < 27; b++)
          drive(0, 2'(md), tri_code(a, NS), tri_code(b, NS));

    // random operands on the wide instance
    for (int md = 0; md < 4; md++)
      for (int k = 0; k < 400; k++)
        drive(1, 2'(md), rnd_op(), rnd_op());

    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, n_checks);
    $finish;
  end
endmodule